// File: doc/BRIEF.md
# Compressed Encoding Mode Sequencer

This block follows an instruction stream that mixes ordinary 32-bit words with two compressed forms. One is a 10-bit form, reached from standard code through one of two adjacent major opcodes. The other is a 16-bit form that uses the whole parcel. Each cycle it looks at one 16-bit parcel from the fetch buffer and reports four things: what that parcel is, whether it belongs to a 32-bit word, which compressed format it carries, and whether it is illegal. It also reports the mode that will apply to the next parcel.

The mode is not fixed by length bits in each parcel. Continuation bits inside every compressed instruction set it. The last bit of the parcel (M) decides it in the 10-bit form. The first and last bits (N, M) decide it in the 16-bit form. One of those codes allows a single standard instruction and then resumes 16-bit decoding. The mode advances only when a parcel is accepted. Trap logic can read the mode and write it back, so it can save and restore the mode around a handler.

Bits are numbered from the most significant end: bit 0 of the parcel is `parcel_i[15]` and bit f is `parcel_i[0]`. The mode is a 3-bit code. Bits [1:0] hold the stream kind: 00 standard, 01 compressed-16, 10 one-shot standard (return to compressed-16 afterwards). Bit [2] is set while the block waits for the second parcel of a 32-bit word.

Top module: `cmode_seq`

## Requirements
- R1: After reset, `mode_o` is 000 and `parcel_ready_o` is 1.
- R2: In mode 000, a parcel whose top five bits (`parcel_i[15:11]`) are zero is a 10-bit op (kind 2, `wide_o`=0). Any other parcel is the first half of a 32-bit word: kind 0, `wide_o`=1, format 0, next mode 100.
- R3: When mode bit 2 is set, the parcel is a second half (kind 1, `wide_o`=1, format 0, never illegal) whatever its content. The next mode is 000 from 100 and 001 from 110.
- R4: For a 10-bit op, `parcel_i[0]`=1 gives next mode 001 and `parcel_i[0]`=0 gives next mode 000.
- R5: In mode 001 every parcel is a 16-bit op (kind 3). The next mode comes from {`parcel_i[15]`,`parcel_i[0]`}: 00 gives 000, 01 gives 001, 10 gives 010, 11 gives 001.
- R6: Compressed format codes are 1 plain, 2 sub-encoded, 3 immediate. The code is 2 when `parcel_i[10:7]`=0011. It is 3 only for a 16-bit op with both `parcel_i[15]` and `parcel_i[0]` set that is not sub-encoded. Every other compressed op is 1.
- R7: An all-zero parcel decoded as a 10-bit or 16-bit op gives format 6 and `illegal_o`=1. `illegal_o` is 0 for every other parcel.
- R8: Format 4 (nop) is given for parcel 0001h as a 10-bit op and for 8000h as a 16-bit op. Format 5 (attn) is given for C000h as a 16-bit op. No other parcel gives 4 or 5.
- R9: In mode 010, every parcel starts a 32-bit word (kind 0), even one with zero top bits, and the next mode is 110. Exactly one 32-bit word therefore runs before mode 001 returns.
- R10: The mode changes only on a cycle where `parcel_valid_i` and `parcel_ready_o` are both high. Otherwise it holds.
- R11: `mode_o` shows the current mode. A cycle with `trap_wr_i` high loads `trap_mode_i`, which takes priority over everything else. If the written kind field is 11, the mode becomes 000. `parcel_ready_o` is low during that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| parcel_i | input | 16 | Current parcel, bit 0 of the encoding at [15] |
| parcel_valid_i | input | 1 | Parcel is present |
| parcel_ready_o | output | 1 | Parcel will be accepted this cycle |
| kind_o | output | 2 | 0 word first half, 1 word second half, 2 10-bit op, 3 16-bit op |
| fmt_o | output | 3 | 0 none, 1 plain, 2 sub, 3 immediate, 4 nop, 5 attn, 6 illegal |
| wide_o | output | 1 | Parcel belongs to a 32-bit word |
| illegal_o | output | 1 | Parcel is an illegal compressed op |
| next_mode_o | output | 3 | Mode that applies after this parcel |
| mode_o | output | 3 | Current mode, for trap save |
| trap_wr_i | input | 1 | Load mode from trap logic |
| trap_mode_i | input | 3 | Mode value to restore |

## Verification
A wrong mode is visible at once, because `kind_o` and `next_mode_o` for the very next parcel depend on it. A missing half flag shows up as a second-half parcel being reported as a compressed op or as a new word, within one accepted parcel. A stuck one-shot state shows up two accepted parcels after the excursion starts, when `mode_o` fails to return to 001. The sweeps load each mode through the trap port, present one parcel, and check both the classification for that same cycle and `mode_o` on the following cycle. Every state error therefore appears within two clock cycles.

// File: rtl/cmode_pkg.sv
package cmode_pkg;
  localparam int PW = 16;
  localparam int MW = 3;

  localparam logic [MW-1:0] MODE_STD    = 3'b000;
  localparam logic [MW-1:0] MODE_C16    = 3'b001;
  localparam logic [MW-1:0] MODE_ONE    = 3'b010;
  localparam logic [MW-1:0] MODE_STD_HI = 3'b100;
  localparam logic [MW-1:0] MODE_ONE_HI = 3'b110;

  localparam logic [1:0] STRM_STD = 2'b00;
  localparam logic [1:0] STRM_C16 = 2'b01;
  localparam logic [1:0] STRM_ONE = 2'b10;
  localparam logic [1:0] STRM_BAD = 2'b11;

  localparam logic [3:0] SUB_OP = 4'b0011;

  typedef enum logic [1:0] {
    K_WORD_LO = 2'd0,
    K_WORD_HI = 2'd1,
    K_C10     = 2'd2,
    K_C16     = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    F_NONE  = 3'd0,
    F_PLAIN = 3'd1,
    F_SUB   = 3'd2,
    F_IMM   = 3'd3,
    F_NOP   = 3'd4,
    F_ATTN  = 3'd5,
    F_ILL   = 3'd6
  } fmt_e;
endpackage

// File: rtl/cmode_fmt.sv
module cmode_fmt
  import cmode_pkg::*;
(
  input  logic [PW-1:0] parcel_i,
  input  logic          full16_i,
  output fmt_e          fmt_o
);
  logic is_sub, is_zero, n_bit, m_bit;

  assign is_sub  = (parcel_i[10:7] == SUB_OP);
  assign is_zero = (parcel_i == '0);
  assign n_bit   = parcel_i[PW-1];
  assign m_bit   = parcel_i[0];

  always_comb begin
    if (is_zero)                                   fmt_o = F_ILL;
    else if (!full16_i && parcel_i == 16'h0001)    fmt_o = F_NOP;
    else if (full16_i && parcel_i == 16'h8000)     fmt_o = F_NOP;
    else if (full16_i && parcel_i == 16'hC000)     fmt_o = F_ATTN;
    else if (is_sub)                               fmt_o = F_SUB;
    else if (full16_i && n_bit && m_bit)           fmt_o = F_IMM;
    else                                           fmt_o = F_PLAIN;
  end
endmodule

// File: rtl/cmode_decode.sv
module cmode_decode
  import cmode_pkg::*;
(
  input  logic [PW-1:0] parcel_i,
  input  logic [MW-1:0] mode_i,
  output kind_e         kind_o,
  output fmt_e          fmt_o,
  output logic [MW-1:0] next_o,
  output logic          wide_o,
  output logic          illegal_o
);
  logic       half;
  logic [1:0] strm;
  logic       ext_hit;
  fmt_e       cfmt;

  assign half    = mode_i[2];
  assign strm    = mode_i[1:0];
  assign ext_hit = (parcel_i[PW-1:PW-5] == '0);

  cmode_fmt u_fmt (
    .parcel_i (parcel_i),
    .full16_i (strm == STRM_C16),
    .fmt_o    (cfmt)
  );

  always_comb begin
    kind_o = K_WORD_LO;
    next_o = MODE_STD_HI;
    if (half) begin
      kind_o = K_WORD_HI;
      next_o = (strm == STRM_ONE) ? MODE_C16 : MODE_STD;
    end else if (strm == STRM_ONE) begin
      kind_o = K_WORD_LO;
      next_o = MODE_ONE_HI;
    end else if (strm == STRM_C16) begin
      kind_o = K_C16;
      unique case ({parcel_i[PW-1], parcel_i[0]})
        2'b00:   next_o = MODE_STD;
        2'b10:   next_o = MODE_ONE;
        default: next_o = MODE_C16;
      endcase
    end else if (ext_hit) begin
      kind_o = K_C10;
      next_o = parcel_i[0] ? MODE_C16 : MODE_STD;
    end
  end

  assign wide_o    = (kind_o == K_WORD_LO) || (kind_o == K_WORD_HI);
  assign fmt_o     = wide_o ? F_NONE : cfmt;
  assign illegal_o = (fmt_o == F_ILL);
endmodule

// File: rtl/cmode_state.sv
module cmode_state
  import cmode_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [MW-1:0] next_i,
  input  logic          wr_i,
  input  logic [MW-1:0] wdata_i,
  output logic [MW-1:0] mode_o
);
  logic [MW-1:0] mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_STD;
    else if (wr_i)      mode_q <= (wdata_i[1:0] == STRM_BAD) ? MODE_STD : wdata_i;
    else if (accept_i)  mode_q <= next_i;
  end

  assign mode_o = mode_q;

  assert_kind_legal_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q[1:0] != STRM_BAD);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept_i && !wr_i) |=> $stable(mode_q));

  assert_half_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !wr_i && mode_q[2]) |=> !mode_q[2]);

  assert_oneshot_back_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !wr_i && mode_q == MODE_ONE_HI) |=> mode_q == MODE_C16);
endmodule

// File: rtl/cmode_seq.sv
module cmode_seq
  import cmode_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] parcel_i,
  input  logic        parcel_valid_i,
  output logic        parcel_ready_o,
  output logic [1:0]  kind_o,
  output logic [2:0]  fmt_o,
  output logic        wide_o,
  output logic        illegal_o,
  output logic [2:0]  next_mode_o,
  output logic [2:0]  mode_o,
  input  logic        trap_wr_i,
  input  logic [2:0]  trap_mode_i
);
  logic [MW-1:0] mode_q;
  logic          accept;
  kind_e         kind;
  fmt_e          fmt;

  assign parcel_ready_o = !trap_wr_i;
  assign accept         = parcel_valid_i && parcel_ready_o;

  cmode_decode u_dec (
    .parcel_i  (parcel_i),
    .mode_i    (mode_q),
    .kind_o    (kind),
    .fmt_o     (fmt),
    .next_o    (next_mode_o),
    .wide_o    (wide_o),
    .illegal_o (illegal_o)
  );

  cmode_state u_st (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .next_i   (next_mode_o),
    .wr_i     (trap_wr_i),
    .wdata_i  (trap_mode_i),
    .mode_o   (mode_q)
  );

  assign kind_o = kind;
  assign fmt_o  = fmt;
  assign mode_o = mode_q;

  assert_illegal_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> parcel_i == '0);

  assert_word_no_fmt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_o |-> (fmt == F_NONE && !illegal_o));

  assert_c10_only_std_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind == K_C10) |-> (mode_q == MODE_STD));
endmodule

// File: tb/cmode_seq_bench.sv
module cmode_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] parcel = '0;
  logic        valid = 1'b0;
  logic        ready;
  logic [1:0]  kind;
  logic [2:0]  fmt;
  logic        wide, ill;
  logic [2:0]  nxt, mode;
  logic        twr = 1'b0;
  logic [2:0]  tmode = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmode_seq u_cmode_seq (
    .clk_i(clk), .rst_ni(rst_n), .parcel_i(parcel), .parcel_valid_i(valid),
    .parcel_ready_o(ready), .kind_o(kind), .fmt_o(fmt), .wide_o(wide),
    .illegal_o(ill), .next_mode_o(nxt), .mode_o(mode),
    .trap_wr_i(twr), .trap_mode_i(tmode)
  );

  // expected {kind,fmt,wide,ill,next}
  function automatic logic [9:0] model(input logic [2:0] m, input logic [15:0] p);
    logic [1:0] k; logic [2:0] f; logic [2:0] n; logic w;
    f = 3'd0;
    if (m[2]) begin
      k = 2'd1; n = (m[1:0] == 2'b10) ? 3'b001 : 3'b000;
    end else if (m[1:0] == 2'b10) begin
      k = 2'd0; n = 3'b110;
    end else if (m[1:0] == 2'b01) begin
      k = 2'd3;
      case ({p[15], p[0]})
        2'b00: n = 3'b000;
        2'b10: n = 3'b010;
        default: n = 3'b001;
      endcase
    end else if (p[15:11] == 5'd0) begin
      k = 2'd2; n = p[0] ? 3'b001 : 3'b000;
    end else begin
      k = 2'd0; n = 3'b100;
    end
    w = (k < 2);
    if (!w) begin
      if (p == 16'h0) f = 3'd6;
      else if (k == 2'd2 && p == 16'h0001) f = 3'd4;
      else if (k == 2'd3 && p == 16'h8000) f = 3'd4;
      else if (k == 2'd3 && p == 16'hC000) f = 3'd5;
      else if (p[10:7] == 4'b0011) f = 3'd2;
      else if (k == 2'd3 && p[15] && p[0]) f = 3'd3;
      else f = 3'd1;
    end
    return {k, f, w, (f == 3'd6), n};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called just after a negedge; returns just after a later negedge
  task automatic apply(input string req, input logic [2:0] m, input logic [15:0] p);
    logic [9:0] e;
    twr = 1'b1; tmode = m; valid = 1'b0;
    @(negedge clk);
    twr = 1'b0; valid = 1'b1; parcel = p;
    #1;
    e = model(m, p);
    chk(req, {22'd0, kind, fmt, wide, ill, nxt}, {22'd0, e});
    @(negedge clk);
    valid = 1'b0;
    #1;
    chk("R10", {29'd0, mode}, {29'd0, e[2:0]});
  endtask

  task automatic feed(input string req, input logic [15:0] p, input logic [1:0] ek,
                      input logic [2:0] em);
    parcel = p; valid = 1'b1;
    #1;
    chk(req, {30'd0, kind}, {30'd0, ek});
    @(negedge clk);
    valid = 1'b0;
    #1;
    chk(req, {29'd0, mode}, {29'd0, em});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    #1;
    chk("R1", {29'd0, mode}, 32'd0);
    chk("R1", {31'd0, ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    #1;

    // R5 R6 R7 R8: full sweep of the 16-bit form
    for (int i = 0; i < 65536; i++) apply("R5", 3'b001, 16'(i));
    // R2 R4: every 10-bit parcel
    for (int i = 0; i < 2048; i++) apply("R4", 3'b000, 16'(i));
    // R2: parcels that start a word
    for (int i = 2048; i < 65536; i += 1031) apply("R2", 3'b000, 16'(i));
    // R9: one-shot first half, including zero top bits
    for (int i = 0; i < 65536; i += 257) apply("R9", 3'b010, 16'(i));
    apply("R9", 3'b010, 16'h0001);
    // R3: second halves from both word kinds
    for (int i = 0; i < 65536; i += 257) apply("R3", 3'b100, 16'(i));
    for (int i = 0; i < 65536; i += 257) apply("R3", 3'b110, 16'(i));
    apply("R8", 3'b000, 16'h0001);
    apply("R7", 3'b000, 16'h0000);

    // R9 sequence: into 16-bit, one-shot, one word, back
    apply("R4", 3'b000, 16'h0401);
    feed("R9", 16'h8002, 2'd3, 3'b010);
    feed("R9", 16'h0000, 2'd0, 3'b110);
    feed("R9", 16'h0000, 2'd1, 3'b001);
    feed("R5", 16'h0002, 2'd3, 3'b000);
    feed("R2", 16'h7C00, 2'd0, 3'b100);
    feed("R3", 16'h0000, 2'd1, 3'b000);

    // R10: no accept without valid
    parcel = 16'h0001; valid = 1'b0;
    @(negedge clk); #1;
    chk("R10", {29'd0, mode}, 32'd0);

    // R11: bad kind, ready low, priority over valid
    twr = 1'b1; tmode = 3'b011; valid = 1'b1; parcel = 16'h0001;
    #1;
    chk("R11", {31'd0, ready}, 32'd0);
    @(negedge clk); twr = 1'b0; valid = 1'b0; #1;
    chk("R11", {29'd0, mode}, 32'd0);
    twr = 1'b1; tmode = 3'b110; valid = 1'b1; parcel = 16'h0001;
    @(negedge clk); twr = 1'b0; valid = 1'b0; #1;
    chk("R11", {29'd0, mode}, 32'd6);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule